// File: doc/BRIEF.md
# Adapter Status and Interrupt Controller

This block keeps the host-side control and status state of a bus-bridge adapter and presents it through four 8-bit registers. Software uses a command register to drop sticky error flags, to acknowledge a doorbell from the far side and to ring a doorbell toward it. An interrupt control register holds two enables and a 3-bit selector for the cable interrupt line that the outgoing doorbell uses. Two read-only registers report the sticky error flags, the received doorbell, the link state and the pending remote cable interrupt lines.

Error events and the incoming doorbell arrive as one-cycle pulses. The link-down condition and the remote cable interrupt lines arrive as levels. The block merges all of these into one level-sensitive interrupt toward the host. Normal events (doorbell and cable lines) and error events are gated by separate enables. Register reads are combinational from the stored state. Register writes take effect at the clock edge that samples them.

Top module: `adapter_irq_ctl`

## Requirements
- R1: Registers sit at offset 0 (command), 1 (interrupt control), 2 (status) and 3 (cable status). After reset every register reads 0x00, and `host_irq`, `doorbell_out` and `cable_sel` are 0.
- R2: A pulse on `err_pulse` sets a sticky status flag at the edge that samples it. The mapping is bit 3 to status bit 7 (parity), bit 2 to status bit 6 (remote bus), bit 1 to status bit 2 (timeout) and bit 0 to status bit 1 (checksum). A flag stays set until it is cleared.
- R3: Writing 1 to command bit 7 clears the four error flags at that edge. Command bit 7 always reads 0, and the command has no effect on status bit 0.
- R4: When a set pulse meets a clear command in the same cycle, the set wins. This applies to the error flags and to the received doorbell.
- R5: A pulse on `db_rx_pulse` sets status bit 5. Writing 1 to command bit 6 clears it. Command bit 6 always reads 0.
- R6: Command bit 5 is read/write and drives `doorbell_out`.
- R7: Interrupt control bit 6 (normal enable), bit 5 (error enable) and bits 2:0 (line select) are read/write. Bits 2:0 drive `cable_sel`.
- R8: `host_irq` = (normal enable AND (status bit 5 OR any cable status bit)) OR (error enable AND (any error flag OR status bit 0)). Interrupt control bit 7 reads the same value as `host_irq`, and writes to bit 7 are ignored.
- R9: Cable status bits 7:1 report `cable_lines[6:0]` as sampled at the previous clock edge. Bit 0 reads 0.
- R10: Status bit 0 reports `link_down` as sampled at the previous clock edge.
- R11: Bits 4:3 of the status and interrupt control registers read 0, and so do command bits 4:0. Writes to offsets 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| err_pulse | input | 4 | Error event pulses: parity, remote bus, timeout, checksum |
| db_rx_pulse | input | 1 | Doorbell received from the remote side |
| link_down | input | 1 | Level: remote power or cable missing |
| cable_lines | input | 7 | Remote cable interrupt lines 7..1 |
| host_irq | output | 1 | Level interrupt toward the host |
| doorbell_out | output | 1 | Doorbell toward the remote side |
| cable_sel | output | 3 | Selected cable interrupt line |

## Verification
A set event and the clear command that erases it can land on the same clock edge. This can happen for the error flags and for the received doorbell. The bench drives an error pulse in the same cycle as a command write with bit 7 set. It also drives a doorbell pulse together with a command write with bit 6 set. It then reads the status register: the pulsed flag must be set and every other error flag must be cleared. `host_irq` must also follow the surviving flag.

// File: rtl/adapter_irq_pkg.sv
package adapter_irq_pkg;
    parameter int REG_W   = 8;
    parameter int ADDR_W  = 2;
    parameter int SEL_W   = 3;
    parameter int CABLE_N = 7;
    parameter int ERR_N   = 4;

    localparam logic [ADDR_W-1:0] OFF_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] OFF_ICTL = 2'd1;
    localparam logic [ADDR_W-1:0] OFF_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] OFF_CINT = 2'd3;

    localparam int CMD_CLR_ERR = 7;
    localparam int CMD_CLR_DB  = 6;
    localparam int CMD_DB_OUT  = 5;
    localparam int ICTL_PEND   = 7;
    localparam int ICTL_NEN    = 6;
    localparam int ICTL_EEN    = 5;
    localparam int STAT_PAR    = 7;
    localparam int STAT_BUS    = 6;
    localparam int STAT_DB     = 5;
    localparam int STAT_TMO    = 2;
    localparam int STAT_LRC    = 1;
    localparam int STAT_NOC    = 0;

    typedef struct packed {
        logic               nen;
        logic               een;
        logic [SEL_W-1:0]   sel;
        logic               db_out;
        logic               nocon;
        logic [CABLE_N-1:0] cable;
    } ctl_state_t;
endpackage

// File: rtl/adapter_flag_bank.sv
module adapter_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d;
    logic [N-1:0] flags_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flags_d[i] = set_i[i] | (flags_q[i] & ~clr_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/adapter_irq_merge.sv
module adapter_irq_merge #(
    parameter int CABLE_N = 7,
    parameter int ERR_N   = 4
) (
    input  logic               nen,
    input  logic               een,
    input  logic               db_rx,
    input  logic [CABLE_N-1:0] cable,
    input  logic [ERR_N-1:0]   errs,
    input  logic               nocon,
    output logic               irq
);
    logic normal_src;
    logic error_src;

    always_comb begin
        normal_src = db_rx | (|cable);
        error_src  = (|errs) | nocon;
        irq        = (nen & normal_src) | (een & error_src);
    end
endmodule

// File: rtl/adapter_read_mux.sv
module adapter_read_mux
    import adapter_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  ctl_state_t        st,
    input  logic [ERR_N-1:0]  errs,
    input  logic              db_rx,
    input  logic              irq,
    output logic [REG_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CMD: begin
                rdata[CMD_DB_OUT] = st.db_out;
            end
            OFF_ICTL: begin
                rdata[ICTL_PEND]   = irq;
                rdata[ICTL_NEN]    = st.nen;
                rdata[ICTL_EEN]    = st.een;
                rdata[SEL_W-1:0]   = st.sel;
            end
            OFF_STAT: begin
                rdata[STAT_PAR] = errs[3];
                rdata[STAT_BUS] = errs[2];
                rdata[STAT_DB]  = db_rx;
                rdata[STAT_TMO] = errs[1];
                rdata[STAT_LRC] = errs[0];
                rdata[STAT_NOC] = st.nocon;
            end
            default: begin
                rdata[REG_W-1:1] = st.cable;
            end
        endcase
    end
endmodule

// File: rtl/adapter_irq_ctl.sv
module adapter_irq_ctl
    import adapter_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [ERR_N-1:0]   err_pulse,
    input  logic               db_rx_pulse,
    input  logic               link_down,
    input  logic [CABLE_N-1:0] cable_lines,
    output logic               host_irq,
    output logic               doorbell_out,
    output logic [SEL_W-1:0]   cable_sel
);
    ctl_state_t       st_d;
    ctl_state_t       st_q;
    logic             wr_cmd;
    logic             wr_ictl;
    logic             clr_err;
    logic             clr_db;
    logic [ERR_N-1:0] err_flags;
    logic [0:0]       db_rx_q;
    logic             irq;

    always_comb begin
        wr_cmd  = reg_wr && (reg_addr == OFF_CMD);
        wr_ictl = reg_wr && (reg_addr == OFF_ICTL);
        clr_err = wr_cmd && reg_wdata[CMD_CLR_ERR];
        clr_db  = wr_cmd && reg_wdata[CMD_CLR_DB];

        st_d       = st_q;
        st_d.nocon = link_down;
        st_d.cable = cable_lines;
        if (wr_cmd) begin
            st_d.db_out = reg_wdata[CMD_DB_OUT];
        end
        if (wr_ictl) begin
            st_d.nen = reg_wdata[ICTL_NEN];
            st_d.een = reg_wdata[ICTL_EEN];
            st_d.sel = reg_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    adapter_flag_bank #(.N(ERR_N)) u_err_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (err_pulse),
        .clr_i   (clr_err),
        .flags_o (err_flags)
    );

    adapter_flag_bank #(.N(1)) u_db_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (db_rx_pulse),
        .clr_i   (clr_db),
        .flags_o (db_rx_q)
    );

    adapter_irq_merge #(.CABLE_N(CABLE_N), .ERR_N(ERR_N)) u_merge (
        .nen   (st_q.nen),
        .een   (st_q.een),
        .db_rx (db_rx_q[0]),
        .cable (st_q.cable),
        .errs  (err_flags),
        .nocon (st_q.nocon),
        .irq   (irq)
    );

    adapter_read_mux u_rmux (
        .addr  (reg_addr),
        .st    (st_q),
        .errs  (err_flags),
        .db_rx (db_rx_q[0]),
        .irq   (irq),
        .rdata (reg_rdata)
    );

    assign host_irq     = irq;
    assign doorbell_out = st_q.db_out;
    assign cable_sel    = st_q.sel;
endmodule

// File: rtl/adapter_irq_chk.sv
module adapter_irq_chk
    import adapter_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic [ERR_N-1:0]   err_pulse,
    input logic               db_rx_pulse,
    input logic               host_irq,
    input logic               doorbell_out,
    input logic [SEL_W-1:0]   cable_sel,
    input logic [ERR_N-1:0]   err_q,
    input logic               db_q
);
    logic clr_err_w;
    assign clr_err_w = reg_wr && (reg_addr == OFF_CMD) && reg_wdata[CMD_CLR_ERR];

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse != '0) |=> ((err_q & $past(err_pulse)) == $past(err_pulse)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err_w |=> ((err_q & $past(err_q)) == $past(err_q)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err_w && err_pulse == '0) |=> (err_q == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err_w && err_pulse != '0) |=> (err_q == $past(err_pulse)));

    p_db_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        db_rx_pulse |=> db_q);

    p_db_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CMD) |=> (doorbell_out == $past(reg_wdata[CMD_DB_OUT])));

    p_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_ICTL) |=> (cable_sel == $past(reg_wdata[SEL_W-1:0])));

    p_pend_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_ICTL) |-> (reg_rdata[ICTL_PEND] == host_irq));

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_ICTL || reg_addr == OFF_STAT) |-> (reg_rdata[4:3] == 2'b00));
endmodule

bind adapter_irq_ctl adapter_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .err_pulse    (err_pulse),
    .db_rx_pulse  (db_rx_pulse),
    .host_irq     (host_irq),
    .doorbell_out (doorbell_out),
    .cable_sel    (cable_sel),
    .err_q        (err_flags),
    .db_q         (db_rx_q[0])
);

// File: tb/tb_adapter_irq_ctl.sv
module tb_adapter_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] err_pulse = '0;
    logic       db_rx_pulse = 1'b0;
    logic       link_down = 1'b0;
    logic [6:0] cable_lines = '0;
    logic       host_irq;
    logic       doorbell_out;
    logic [2:0] cable_sel;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adapter_irq_ctl dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_pulse(err_pulse),
        .db_rx_pulse(db_rx_pulse), .link_down(link_down), .cable_lines(cable_lines),
        .host_irq(host_irq), .doorbell_out(doorbell_out), .cable_sel(cable_sel)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] waddr;
        logic [7:0] wdata;
        logic [3:0] errp;
        logic       dbp;
        logic [1:0] raddr;
        logic [7:0] exp;
        logic       exp_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 8'h00, 4'b0000, 1'b0, 2'd1, 8'h00, 1'b0, 4'd7},  // R7 idle control
        '{1'b0, 2'd0, 8'h00, 4'b1000, 1'b0, 2'd2, 8'h80, 1'b0, 4'd2},  // R2 parity, gated off
        '{1'b1, 2'd1, 8'h20, 4'b0000, 1'b0, 2'd1, 8'hA0, 1'b1, 4'd8},  // R8 error enable
        '{1'b1, 2'd0, 8'h80, 4'b0000, 1'b0, 2'd2, 8'h00, 1'b0, 4'd3},  // R3 clear
        '{1'b0, 2'd0, 8'h00, 4'b0110, 1'b0, 2'd2, 8'h44, 1'b1, 4'd2},  // R2 bus+timeout
        '{1'b0, 2'd0, 8'h00, 4'b0001, 1'b0, 2'd2, 8'h46, 1'b1, 4'd2},  // R2 checksum, sticky
        '{1'b1, 2'd0, 8'h80, 4'b1000, 1'b0, 2'd2, 8'h80, 1'b1, 4'd4},  // R4 set beats clear
        '{1'b1, 2'd0, 8'h80, 4'b0000, 1'b0, 2'd2, 8'h00, 1'b0, 4'd3},  // R3 clear again
        '{1'b0, 2'd0, 8'h00, 4'b0000, 1'b1, 2'd2, 8'h20, 1'b0, 4'd5},  // R5 doorbell, normal off
        '{1'b1, 2'd1, 8'h45, 4'b0000, 1'b0, 2'd1, 8'hC5, 1'b1, 4'd8},  // R8 normal enable
        '{1'b1, 2'd0, 8'h40, 4'b0000, 1'b0, 2'd2, 8'h00, 1'b0, 4'd5},  // R5 ack doorbell
        '{1'b1, 2'd0, 8'h20, 4'b0000, 1'b0, 2'd0, 8'h20, 1'b0, 4'd6},  // R6 ring out
        '{1'b1, 2'd1, 8'hFF, 4'b0000, 1'b0, 2'd1, 8'h67, 1'b0, 4'd11}, // R11 reserved/ro
        '{1'b1, 2'd2, 8'hFF, 4'b0000, 1'b0, 2'd2, 8'h00, 1'b0, 4'd11}, // R11 status ro
        '{1'b1, 2'd3, 8'hFF, 4'b0000, 1'b0, 2'd3, 8'h00, 1'b0, 4'd11}, // R11 cable ro
        '{1'b1, 2'd0, 8'hC0, 4'b0000, 1'b0, 2'd0, 8'h00, 1'b0, 4'd6},  // R6 drop, R3 reads 0
        '{1'b1, 2'd0, 8'h40, 4'b0000, 1'b1, 2'd2, 8'h20, 1'b1, 4'd4},  // R4 doorbell wins
        '{1'b1, 2'd0, 8'h40, 4'b0000, 1'b0, 2'd2, 8'h00, 1'b0, 4'd5},  // R5 ack
        '{1'b0, 2'd0, 8'h00, 4'b1111, 1'b0, 2'd2, 8'hC6, 1'b1, 4'd2},  // R2 all errors
        '{1'b1, 2'd1, 8'h40, 4'b0000, 1'b0, 2'd1, 8'h40, 1'b0, 4'd8},  // R8 error gate off
        '{1'b1, 2'd0, 8'h80, 4'b0000, 1'b0, 2'd2, 8'h00, 1'b0, 4'd3}   // R3 clear all
    };

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_check(input int req, input logic [1:0] a, input logic [7:0] exp, input logic exp_irq);
        reg_addr = a;
        #2;
        check(req, "rdata", reg_rdata, exp);
        check(req, "host_irq", {7'd0, host_irq}, {7'd0, exp_irq});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of all registers and outputs
        for (int a = 0; a < 4; a++) read_check(1, a[1:0], 8'h00, 1'b0);
        check(1, "doorbell_out", {7'd0, doorbell_out}, 8'h00);
        check(1, "cable_sel", {5'd0, cable_sel}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr = VECS[i].wr; reg_addr = VECS[i].waddr; reg_wdata = VECS[i].wdata;
            err_pulse = VECS[i].errp; db_rx_pulse = VECS[i].dbp;
            @(negedge clk);
            reg_wr = 1'b0; err_pulse = '0; db_rx_pulse = 1'b0;
            read_check(int'(VECS[i].req), VECS[i].raddr, VECS[i].exp, VECS[i].exp_irq);
        end

        // R9 cable lines, normal enable on (control = 0x40)
        @(negedge clk); cable_lines = 7'b0000100;
        @(negedge clk); read_check(9, 2'd3, 8'h08, 1'b1);
        cable_lines = 7'b1000000;
        @(negedge clk); read_check(9, 2'd3, 8'h80, 1'b1);
        cable_lines = '0;
        @(negedge clk); read_check(9, 2'd3, 8'h00, 1'b0);

        // R10 link state, error enable only
        do_write(2'd1, 8'h20);
        link_down = 1'b1;
        @(negedge clk); read_check(10, 2'd2, 8'h01, 1'b1);
        // R3 clear leaves the link bit alone
        do_write(2'd0, 8'h80);
        read_check(3, 2'd2, 8'h01, 1'b1);
        link_down = 1'b0;
        @(negedge clk); read_check(10, 2'd2, 8'h00, 1'b0);

        // R6 / R7 output ports
        do_write(2'd0, 8'h20);
        check(6, "doorbell_out", {7'd0, doorbell_out}, 8'h01);
        do_write(2'd1, 8'h23);
        check(7, "cable_sel", {5'd0, cable_sel}, 8'h03);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule